// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Timer

This block drives the active-low system reset of a supervisory device. It keeps the system in reset while the supply-good flag is low. Once the flag rises, it keeps reset asserted for a hold time chosen by a one-bit field. After release, it runs a watchdog that must be kicked. If no kick arrives within the selected timeout, the watchdog pulls reset for the same hold time and then starts again.

All timing is counted in periods of an input millisecond tick, so the default parameters give millisecond values. A bench can shrink them by passing smaller counts and ticking faster. The hold-time bit and the two-bit watchdog code come from configuration bits held elsewhere and are read live. Voltage comparison is not done here: supply-good arrives as a digital flag.

Top module: `sup_reset_wdt`

## Requirements
- R1: While `supply_ok_i` is low, `sys_rst_no` is low in the same cycle, with no clock edge in between.
- R2: After `supply_ok_i` rises, `sys_rst_no` stays low until the HOLD_SHORT-th tick (default 150) when `pup_i`=0, or the HOLD_LONG-th tick (default 800) when `pup_i`=1. It goes high on the clock edge that samples that tick.
- R3: A low period on `supply_ok_i` during the hold restarts the hold count from zero.
- R4: With reset released and no kick, `sys_rst_no` goes low on the edge of the N-th tick. `wd_sel_i`=2'b00 gives N=WDT_LONG (800), 2'b01 gives N=WDT_MID (400) and 2'b10 gives N=WDT_SHORT (150).
- R5: `wd_sel_i`=2'b11 disables the watchdog, so `sys_rst_no` stays high for any number of ticks while supply is good.
- R6: A rising edge on `kick_i` restarts the watchdog count from zero. Holding `kick_i` high gives no further restart.
- R7: The watchdog does not count while reset is asserted. Its first timeout after a release is a full N ticks.
- R8: After a watchdog timeout, reset stays low for the hold time chosen by `pup_i` and is then released. The watchdog then starts a fresh full count.
- R9: Any change of `wd_sel_i` restarts the watchdog count from zero under the new code.
- R10: While `rst_ni` is low, `sys_rst_no` is low. After `rst_ni` rises with supply good, the full hold time applies.
- R11: Time advances only on cycles where `tick_i` is high. Clock cycles without a tick leave the counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply-good flag, high when the supply is within limits |
| kick_i | input | 1 | Watchdog kick; its rising edge restarts the count |
| tick_i | input | 1 | One-cycle pulse per millisecond |
| pup_i | input | 1 | Hold-time select: 0 short, 1 long |
| wd_sel_i | input | 2 | Watchdog timeout code; 2'b11 disables the watchdog |
| sys_rst_no | output | 1 | System reset, active low |

## Verification
A table walks every pairing of hold select and watchdog code that matters. It checks the reset edge one tick before and exactly at each expected count, so an off-by-one or a swapped code shows up. Directed patterns follow:
- a supply drop part-way through the hold, which separates a restarting count from one that resumes;
- long gaps between ticks, which separate tick counting from cycle counting;
- a kick held high, which separates edge detection from level detection;
- a code change mid-count, which shows whether the count restarts;
- a supply drop during normal running, sampled before the next clock edge, which shows whether reset follows the supply without waiting for an edge.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic {ST_HOLD = 1'b0, ST_RUN = 1'b1} sup_state_e;
  localparam logic [1:0] WDSEL_LONG  = 2'b00;
  localparam logic [1:0] WDSEL_MID   = 2'b01;
  localparam logic [1:0] WDSEL_SHORT = 2'b10;
  localparam logic [1:0] WDSEL_OFF   = 2'b11;
endpackage

// File: rtl/sup_kick_edge.sv
module sup_kick_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic kick_rise_o
);
  logic kick_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kick_q <= 1'b0;
    else         kick_q <= kick_i;
  end
  assign kick_rise_o = kick_i & ~kick_q;
endmodule

// File: rtl/sup_hold.sv
module sup_hold #(
  parameter int unsigned HOLD_SHORT = 150,
  parameter int unsigned HOLD_LONG  = 800,
  parameter int unsigned CNT_W      = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic tick_i,
  input  logic pup_i,
  input  logic wdt_expire_i,
  output logic in_reset_o
);
  import sup_pkg::*;
  localparam logic [CNT_W-1:0] LEN_S = CNT_W'(HOLD_SHORT);
  localparam logic [CNT_W-1:0] LEN_L = CNT_W'(HOLD_LONG);

  sup_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] len;

  assign len     = pup_i ? LEN_L : LEN_S;
  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else if (!supply_ok_i) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_HOLD: if (tick_i) begin
          if (cnt_inc >= len) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_inc;
          end
        end
        ST_RUN: if (wdt_expire_i) begin
          state_q <= ST_HOLD;
          cnt_q   <= '0;
        end
        default: state_q <= ST_HOLD;
      endcase
    end
  end

  // supply loss forces reset without waiting for an edge
  assign in_reset_o = (state_q == ST_HOLD) | ~supply_ok_i;
endmodule

// File: rtl/sup_wdt.sv
module sup_wdt #(
  parameter int unsigned WDT_LONG  = 800,
  parameter int unsigned WDT_MID   = 400,
  parameter int unsigned WDT_SHORT = 150,
  parameter int unsigned CNT_W     = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic       kick_rise_i,
  input  logic [1:0] wd_sel_i,
  output logic       expire_o
);
  import sup_pkg::*;
  localparam logic [CNT_W-1:0] LIM_L = CNT_W'(WDT_LONG);
  localparam logic [CNT_W-1:0] LIM_M = CNT_W'(WDT_MID);
  localparam logic [CNT_W-1:0] LIM_S = CNT_W'(WDT_SHORT);

  logic [1:0]       sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] limit;
  logic             enabled;
  logic             clear;

  always_comb begin
    unique case (wd_sel_i)
      WDSEL_LONG:  limit = LIM_L;
      WDSEL_MID:   limit = LIM_M;
      WDSEL_SHORT: limit = LIM_S;
      default:     limit = '1;
    endcase
  end

  assign enabled  = (wd_sel_i != WDSEL_OFF);
  assign cnt_inc  = cnt_q + 1'b1;
  assign clear    = ~run_i | kick_rise_i | (wd_sel_i != sel_q) | ~enabled;
  assign expire_o = tick_i & ~clear & (cnt_inc >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= WDSEL_OFF;
      cnt_q <= '0;
    end else begin
      sel_q <= wd_sel_i;
      if (clear || expire_o) cnt_q <= '0;
      else if (tick_i)       cnt_q <= cnt_inc;
    end
  end
endmodule

// File: rtl/sup_reset_wdt.sv
module sup_reset_wdt #(
  parameter int unsigned HOLD_SHORT = 150,
  parameter int unsigned HOLD_LONG  = 800,
  parameter int unsigned WDT_LONG   = 800,
  parameter int unsigned WDT_MID    = 400,
  parameter int unsigned WDT_SHORT  = 150
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       kick_i,
  input  logic       tick_i,
  input  logic       pup_i,
  input  logic [1:0] wd_sel_i,
  output logic       sys_rst_no
);
  localparam int unsigned HOLD_MAX = (HOLD_SHORT > HOLD_LONG) ? HOLD_SHORT : HOLD_LONG;
  localparam int unsigned WDT_MAX0 = (WDT_LONG > WDT_MID) ? WDT_LONG : WDT_MID;
  localparam int unsigned WDT_MAX  = (WDT_MAX0 > WDT_SHORT) ? WDT_MAX0 : WDT_SHORT;
  localparam int unsigned HOLD_W   = $clog2(HOLD_MAX + 1);
  localparam int unsigned WDT_W    = $clog2(WDT_MAX + 1);

  logic kick_rise;
  logic in_reset;
  logic wdt_expire;

  sup_kick_edge u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .kick_i      (kick_i),
    .kick_rise_o (kick_rise)
  );

  sup_hold #(
    .HOLD_SHORT (HOLD_SHORT),
    .HOLD_LONG  (HOLD_LONG),
    .CNT_W      (HOLD_W)
  ) u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .supply_ok_i  (supply_ok_i),
    .tick_i       (tick_i),
    .pup_i        (pup_i),
    .wdt_expire_i (wdt_expire),
    .in_reset_o   (in_reset)
  );

  sup_wdt #(
    .WDT_LONG  (WDT_LONG),
    .WDT_MID   (WDT_MID),
    .WDT_SHORT (WDT_SHORT),
    .CNT_W     (WDT_W)
  ) u_wdt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (~in_reset),
    .tick_i      (tick_i),
    .kick_rise_i (kick_rise),
    .wd_sel_i    (wd_sel_i),
    .expire_o    (wdt_expire)
  );

  assign sys_rst_no = ~in_reset;
endmodule

// File: rtl/sup_reset_wdt_chk.sv
module sup_reset_wdt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       supply_ok_i,
  input logic       kick_i,
  input logic       tick_i,
  input logic [1:0] wd_sel_i,
  input logic       sys_rst_no
);
  logic       kick_d;
  logic [1:0] sel_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kick_d <= 1'b0;
      sel_d  <= 2'b11;
    end else begin
      kick_d <= kick_i;
      sel_d  <= wd_sel_i;
    end
  end

  p_supply_low_rst_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |-> !sys_rst_no);

  p_release_on_tick_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> $past(tick_i));

  p_expiry_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sys_rst_no) && supply_ok_i && $past(supply_ok_i)) |-> $past(tick_i));

  p_disabled_no_expiry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_no && supply_ok_i && wd_sel_i == 2'b11) |=> (sys_rst_no || !supply_ok_i));

  p_kick_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_no && supply_ok_i && kick_i && !kick_d) |=> (sys_rst_no || !supply_ok_i));

  p_code_change_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_no && supply_ok_i && wd_sel_i != sel_d) |=> (sys_rst_no || !supply_ok_i));
endmodule

bind sup_reset_wdt sup_reset_wdt_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .supply_ok_i (supply_ok_i),
  .kick_i      (kick_i),
  .tick_i      (tick_i),
  .wd_sel_i    (wd_sel_i),
  .sys_rst_no  (sys_rst_no)
);

// File: tb/tb_sup_reset_wdt.sv
module tb_sup_reset_wdt;
  localparam time CLK_PERIOD = 10ns;
  localparam int HS = 5, HL = 9, WL = 12, WM = 8, WS = 4;
  // {pup, wd_sel, expected hold ticks, expected timeout ticks (0 = disabled)}
  localparam int NVEC = 6;
  localparam int VEC [NVEC][4] = '{
    '{0, 0, HS, WL}, '{1, 0, HL, WL}, '{0, 1, HS, WM},
    '{1, 2, HL, WS}, '{0, 2, HS, WS}, '{1, 3, HL, 0}
  };

  logic clk = 1'b0, rst_ni = 1'b0, supply_ok_i = 1'b1, kick_i = 1'b0, tick_i = 1'b0, pup_i = 1'b0;
  logic [1:0] wd_sel_i = 2'b11;
  logic sys_rst_no;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sup_reset_wdt #(.HOLD_SHORT(HS), .HOLD_LONG(HL), .WDT_LONG(WL), .WDT_MID(WM), .WDT_SHORT(WS)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok_i), .kick_i(kick_i),
    .tick_i(tick_i), .pup_i(pup_i), .wd_sel_i(wd_sel_i), .sys_rst_no(sys_rst_no));

  task automatic chk(string req, logic exp);
    checks++;
    if (sys_rst_no !== exp) begin
      errors++;
      $display("FAIL %s: sys_rst_no=%b expected %b at %0t", req, sys_rst_no, exp, $time);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1; @(negedge clk);
      tick_i = 1'b0; @(negedge clk);
    end
  endtask

  task automatic supply_cycle();
    supply_ok_i = 1'b0; @(negedge clk); @(negedge clk);
    supply_ok_i = 1'b1; @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R10 reset state and hold after reset release
    repeat (3) @(negedge clk);
    chk("R10 in rst_ni", 1'b0);
    rst_ni = 1'b1; @(negedge clk);
    ticks(HS - 1); chk("R10 hold before end", 1'b0);
    ticks(1);      chk("R10 released", 1'b1);

    // table: hold time per pup, timeout per code, restart after expiry
    for (int v = 0; v < NVEC; v++) begin
      pup_i = VEC[v][0][0]; wd_sel_i = VEC[v][1][1:0];
      supply_ok_i = 1'b0; @(negedge clk);
      chk("R1 supply low", 1'b0);
      supply_ok_i = 1'b1; @(negedge clk);
      ticks(VEC[v][2] - 1); chk("R2 hold not done", 1'b0);
      ticks(1);             chk("R2 hold done", 1'b1);
      if (VEC[v][3] > 0) begin
        ticks(VEC[v][3] - 1); chk("R4 R7 before timeout", 1'b1);
        ticks(1);             chk("R4 timeout", 1'b0);
        ticks(VEC[v][2] - 1); chk("R8 hold after timeout", 1'b0);
        ticks(1);             chk("R8 release after timeout", 1'b1);
        ticks(VEC[v][3] - 1); chk("R8 fresh count", 1'b1);
        ticks(1);             chk("R8 second timeout", 1'b0);
        ticks(VEC[v][2]);
      end else begin
        ticks(3 * WL);        chk("R5 disabled", 1'b1);
      end
    end

    // R3 supply drop mid-hold restarts hold
    pup_i = 1'b0; wd_sel_i = 2'b11;
    supply_cycle(); ticks(3);
    supply_cycle(); ticks(HS - 1); chk("R3 restarted hold", 1'b0);
    ticks(1); chk("R3 release", 1'b1);

    // R11 cycles without tick do not count
    supply_cycle(); repeat (60) @(negedge clk);
    chk("R11 no ticks", 1'b0);
    ticks(HS); chk("R11 release after ticks", 1'b1);

    // R6 kick rising edge restarts; held level does not
    wd_sel_i = 2'b10; @(negedge clk);
    ticks(WS - 1);
    kick_i = 1'b1; @(negedge clk);
    ticks(WS - 1); chk("R6 kick restarted", 1'b1);
    ticks(1);      chk("R6 held kick no restart", 1'b0);
    kick_i = 1'b0;
    ticks(HS);     chk("R6 recover", 1'b1);

    // R9 code change restarts count
    ticks(WS - 1);
    wd_sel_i = 2'b01; @(negedge clk);
    ticks(WM - 1); chk("R9 restarted under new code", 1'b1);
    ticks(1);      chk("R9 new timeout", 1'b0);
    ticks(HS);     chk("R9 recover", 1'b1);

    // R1 drop during run, checked before next edge
    wd_sel_i = 2'b11; @(negedge clk);
    supply_ok_i = 1'b0; #1;
    chk("R1 immediate", 1'b0);
    supply_ok_i = 1'b1; @(negedge clk);
    ticks(HS); chk("R1 recover", 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule